// File: doc/BRIEF.md
# Show-Ahead Single-Clock FIFO

This block is a single-clock first-in first-out buffer. Its storage width and its depth are parameters, and the depth need not be a power of two. A producer offers a word together with a write request. The buffer always drives its oldest stored word on the read data output, without waiting for a request. A consumer that takes that word raises the read request, and the next word is on the output after the following clock edge.

Full and empty are decoded from an occupancy counter rather than from the pointers. A policy parameter selects what happens when a write arrives while the buffer is full. Under the strict policy the write is refused. Under the pass policy the write is taken if a read is taken in the same cycle. Because of this, a write-accepted output tells the producer whether its word was stored.

Top module: `lafifo_top`

## Requirements
- R1: While reset (active-high `rst`) is held, and right after it is released, `empty` is 1, `full` is 0 and `wr_ack` is 0. The first word written after reset is the first word read.
- R2: Words leave in the order they were accepted. Whenever `empty` is 0, `rd_data` shows the oldest word with no request needed. After a clock edge at which a read was taken, `rd_data` shows the next word.
- R3: `full` is 1 exactly when the buffer holds DEPTH words. Under the strict policy, a write request while `full` is 1 is dropped: `wr_ack` stays 0 and the stored words, read out afterwards, are unchanged.
- R4: A read request while `empty` is 1 is ignored: `empty` stays 1, and a later write followed by a read returns that written word.
- R5: When the buffer is neither full nor empty, a write and a read in the same cycle both take effect and the occupancy, and so `full` and `empty`, is unchanged.
- R6: When empty, a write and a read in the same cycle store the word and ignore the read. `rd_data` is not bypassed: the word shows on the next cycle, with `empty` at 0.
- R7: Under the pass policy, a write while `full` is 1 is accepted (`wr_ack` = 1) if `rd_req` is 1 in the same cycle. The buffer stays full, and this may repeat on consecutive cycles with order preserved.
- R8: Under the strict policy, a write and a read while full carry out the read only, so `full` drops to 0 on the next cycle.
- R9: `wr_ack` is 1 in exactly those cycles in which a word is stored.
- R10: Pointers return to slot 0 after slot DEPTH-1, so that a 6-deep buffer keeps order across many wraps.
- R11: A reset asserted mid-operation discards all held words: afterwards `empty` is 1 and order restarts from the next write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of pointers and occupancy |
| wr_data | input | WIDTH | Word offered by the producer |
| wr_req | input | 1 | Producer requests a write |
| full | output | 1 | Buffer holds DEPTH words |
| rd_data | output | WIDTH | Oldest stored word (show-ahead) |
| rd_req | input | 1 | Consumer takes the word on rd_data |
| empty | output | 1 | Buffer holds no words |
| wr_ack | output | 1 | A write is performed this cycle |

## Verification
Two instances are driven by the same requests: an 8-wide 4-deep instance with the strict policy and a 16-wide 6-deep instance with the pass policy. Because the depths differ, the same requests reach the full and empty boundaries at different times in the two. Directed patterns cover the following cases:
- reads on an empty buffer;
- a simultaneous write and read when empty;
- overfilling, where the strict instance refuses and the pass instance is still filling;
- a run of simultaneous writes and reads while full, which separates the two policies;
- a reset in the middle of operation.

A long pseudo-random phase then wraps the non-power-of-two pointers many times, so that an error in the wrap shows up as data out of order.

// File: rtl/lafifo_pkg.sv
package lafifo_pkg;

  typedef enum logic {
    POLICY_STRICT = 1'b0,
    POLICY_PASS   = 1'b1
  } full_policy_e;

  // Next slot index with an explicit wrap, valid for any depth.
  function automatic int unsigned wrap_inc(input int unsigned idx, input int unsigned depth);
    return (idx + 1 >= depth) ? 0 : idx + 1;
  endfunction

  // Occupancy after one cycle of accepted pushes and pops.
  function automatic int unsigned occ_update(input int unsigned occ, input logic push, input logic pop);
    case ({push, pop})
      2'b10:   return occ + 1;
      2'b01:   return occ - 1;
      default: return occ;
    endcase
  endfunction

endpackage

// File: rtl/lafifo_ptr.sv
module lafifo_ptr #(
  parameter int DEPTH = 4,
  parameter int PW    = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  output logic [PW-1:0] ptr
);
  import lafifo_pkg::*;

  logic [PW-1:0] ptr_q;

  always_ff @(posedge clk) begin
    if (rst)      ptr_q <= '0;
    else if (adv) ptr_q <= PW'(wrap_inc(32'(ptr_q), DEPTH));
  end

  assign ptr = ptr_q;

  a_r10_ptr_in_range: assert property (@(posedge clk) disable iff (rst)
    32'(ptr_q) < DEPTH);

  a_r10_ptr_wraps: assert property (@(posedge clk) disable iff (rst)
    (adv && 32'(ptr_q) == DEPTH - 1) |=> ptr_q == '0);

  a_r10_ptr_holds: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(ptr_q));

endmodule

// File: rtl/lafifo_store.sv
module lafifo_store #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4,
  parameter int PW    = 2
) (
  input  logic             clk,
  input  logic             we,
  input  logic [PW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [PW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  // Contents are left uninitialised on reset: every slot is written before it is read.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/lafifo_ctrl.sv
module lafifo_ctrl #(
  parameter int                        DEPTH  = 4,
  parameter int                        CW     = 3,
  parameter lafifo_pkg::full_policy_e  POLICY = lafifo_pkg::POLICY_STRICT
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_req,
  input  logic          rd_req,
  output logic          wr_fire,
  output logic          rd_fire,
  output logic          full,
  output logic          empty,
  output logic [CW-1:0] occ
);
  import lafifo_pkg::*;

  logic [CW-1:0] occ_q;
  logic          room;

  assign full  = (occ_q == CW'(DEPTH));
  assign empty = (occ_q == '0);

  generate
    if (POLICY == POLICY_PASS) begin : g_pass
      assign room = !full || rd_req;

      a_r7_pass_keeps_full: assert property (@(posedge clk) disable iff (rst)
        (full && wr_req && rd_req) |=> full);
    end else begin : g_strict
      assign room = !full;

      a_r8_strict_full_read_drains: assert property (@(posedge clk) disable iff (rst)
        (full && rd_req) |=> !full);
    end
  endgenerate

  assign wr_fire = wr_req && room;
  assign rd_fire = rd_req && !empty;

  always_ff @(posedge clk) begin
    if (rst) occ_q <= '0;
    else     occ_q <= CW'(occ_update(32'(occ_q), wr_fire, rd_fire));
  end

  assign occ = occ_q;

  a_r3_occ_bounded: assert property (@(posedge clk) disable iff (rst)
    occ_q <= CW'(DEPTH));

  a_r1_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(full && empty));

  a_r4_no_underflow: assert property (@(posedge clk) disable iff (rst)
    (empty && !wr_req) |=> empty);

  a_r9_push_grows: assert property (@(posedge clk) disable iff (rst)
    (wr_fire && !rd_fire) |=> occ_q == $past(occ_q) + 1'b1);

  a_r5_both_hold: assert property (@(posedge clk) disable iff (rst)
    (wr_fire && rd_fire) |=> $stable(occ_q));

endmodule

// File: rtl/lafifo_top.sv
module lafifo_top #(
  parameter int                        WIDTH  = 8,
  parameter int                        DEPTH  = 4,
  parameter lafifo_pkg::full_policy_e  POLICY = lafifo_pkg::POLICY_STRICT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             wr_req,
  output logic             full,
  output logic [WIDTH-1:0] rd_data,
  input  logic             rd_req,
  output logic             empty,
  output logic             wr_ack
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic          push_ev;
  logic          pop_ev;
  logic [PW-1:0] wptr;
  logic [PW-1:0] rptr;
  logic [CW-1:0] occ;

  lafifo_ctrl #(.DEPTH(DEPTH), .CW(CW), .POLICY(POLICY)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .wr_req  (wr_req),
    .rd_req  (rd_req),
    .wr_fire (push_ev),
    .rd_fire (pop_ev),
    .full    (full),
    .empty   (empty),
    .occ     (occ)
  );

  lafifo_ptr #(.DEPTH(DEPTH), .PW(PW)) u_wptr (
    .clk (clk),
    .rst (rst),
    .adv (push_ev),
    .ptr (wptr)
  );

  lafifo_ptr #(.DEPTH(DEPTH), .PW(PW)) u_rptr (
    .clk (clk),
    .rst (rst),
    .adv (pop_ev),
    .ptr (rptr)
  );

  lafifo_store #(.WIDTH(WIDTH), .DEPTH(DEPTH), .PW(PW)) u_store (
    .clk   (clk),
    .we    (push_ev),
    .waddr (wptr),
    .wdata (wr_data),
    .raddr (rptr),
    .rdata (rd_data)
  );

  assign wr_ack = push_ev;

  a_r2_head_stable: assert property (@(posedge clk) disable iff (rst)
    (!empty && !rd_req) |=> $stable(rd_data));

  a_r6_no_bypass: assert property (@(posedge clk) disable iff (rst)
    (empty && wr_req) |=> (!empty && occ == CW'(1)));

  a_r3_ptrs_meet_at_edges: assert property (@(posedge clk) disable iff (rst)
    (full || empty) |-> (wptr == rptr));

endmodule

// File: tb/tb_lafifo_top.sv
module tb_lafifo_top;
  import lafifo_pkg::*;

  localparam int DS = 4;
  localparam int DP = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_req = 1'b0;
  logic        rd_req = 1'b0;
  logic [15:0] wr_data = '0;

  logic       full_s, empty_s, ack_s;
  logic [7:0] rd_s;
  logic        full_p, empty_p, ack_p;
  logic [15:0] rd_p;

  int checks = 0;
  int errors = 0;

  logic [7:0]  q_s[$];
  logic [15:0] q_p[$];

  always #2 clk = ~clk;

  lafifo_top #(.WIDTH(8), .DEPTH(DS), .POLICY(POLICY_STRICT)) dut (
    .clk(clk), .rst(rst), .wr_data(wr_data[7:0]), .wr_req(wr_req), .full(full_s),
    .rd_data(rd_s), .rd_req(rd_req), .empty(empty_s), .wr_ack(ack_s)
  );

  lafifo_top #(.WIDTH(16), .DEPTH(DP), .POLICY(POLICY_PASS)) dut_pt (
    .clk(clk), .rst(rst), .wr_data(wr_data), .wr_req(wr_req), .full(full_p),
    .rd_data(rd_p), .rd_req(rd_req), .empty(empty_p), .wr_ack(ack_p)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Monitor: compare flags and head word against the scoreboard queues.
  task automatic check_state(input string tag);
    chk(empty_s == (q_s.size() == 0), tag, "strict empty", 32'(empty_s), 32'(q_s.size() == 0));
    chk(full_s == (q_s.size() == DS), tag, "strict full", 32'(full_s), 32'(q_s.size() == DS));
    if (q_s.size() > 0) chk(rd_s == q_s[0], tag, "strict head", 32'(rd_s), 32'(q_s[0]));
    chk(empty_p == (q_p.size() == 0), tag, "pass empty", 32'(empty_p), 32'(q_p.size() == 0));
    chk(full_p == (q_p.size() == DP), tag, "pass full", 32'(full_p), 32'(q_p.size() == DP));
    if (q_p.size() > 0) chk(rd_p == q_p[0], tag, "pass head", 32'(rd_p), 32'(q_p[0]));
  endtask

  // Driver: apply one cycle of requests, predict acceptance, update the queues.
  task automatic step(input bit w, input bit r, input logic [15:0] d, input string tag);
    bit es_ack, es_pop, ep_ack, ep_pop;
    @(negedge clk);
    wr_req = w; rd_req = r; wr_data = d;
    es_pop = r && (q_s.size() > 0);
    es_ack = w && (q_s.size() < DS);
    ep_pop = r && (q_p.size() > 0);
    ep_ack = w && ((q_p.size() < DP) || r);
    #1;
    chk(ack_s == es_ack, tag, "strict wr_ack (R9)", 32'(ack_s), 32'(es_ack));
    chk(ack_p == ep_ack, tag, "pass wr_ack (R9)", 32'(ack_p), 32'(ep_ack));
    @(posedge clk);
    #1;
    if (es_pop) void'(q_s.pop_front());
    if (es_ack) q_s.push_back(d[7:0]);
    if (ep_pop) void'(q_p.pop_front());
    if (ep_ack) q_p.push_back(d);
    check_state(tag);
  endtask

  task automatic do_reset(input string tag);
    @(negedge clk);
    rst = 1'b1; wr_req = 1'b0; rd_req = 1'b0;
    q_s.delete(); q_p.delete();
    @(negedge clk);
    chk(empty_s && !full_s && !ack_s, tag, "strict reset flags", {29'd0, empty_s, full_s, ack_s}, 32'h4);
    chk(empty_p && !full_p && !ack_p, tag, "pass reset flags", {29'd0, empty_p, full_p, ack_p}, 32'h4);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check_state(tag);
  endtask

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    do_reset("R1");
    // R1: first word after reset is first out
    step(1, 0, 16'h1111, "R1");
    step(0, 1, 16'h0, "R1");
    // R4: reads on empty
    step(0, 1, 16'h0, "R4");
    step(0, 1, 16'h0, "R4");
    step(1, 0, 16'h4242, "R4");
    step(0, 1, 16'h0, "R4");
    // R6: write and read together when empty
    step(1, 1, 16'h6A6A, "R6");
    // R2: show-ahead order
    step(1, 0, 16'h2001, "R2");
    step(1, 0, 16'h2002, "R2");
    step(0, 0, 16'h0, "R2");
    step(0, 1, 16'h0, "R2");
    // R5: simultaneous mid-level
    step(1, 1, 16'h5005, "R5");
    step(1, 1, 16'h5006, "R5");
    // R3: overfill; strict refuses, pass keeps filling
    for (int i = 0; i < 6; i++) step(1, 0, 16'h3000 + 16'(i), "R3");
    // R7/R8: write+read while full, repeated
    for (int i = 0; i < 5; i++) step(1, 1, 16'h7000 + 16'(i), "R7");
    step(1, 1, 16'h8000, "R8");
    // drain both and confirm order (R3 stored words unchanged)
    for (int i = 0; i < 7; i++) step(0, 1, 16'h0, "R3");
    // R10: long pseudo-random run wraps the 6-deep pointers
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0] | lfsr[3], lfsr[1] | lfsr[5], lfsr ^ 16'(i), "R10");
    end
    // R11: reset mid-operation
    step(1, 0, 16'hB001, "R11");
    step(1, 0, 16'hB002, "R11");
    do_reset("R11");
    step(1, 0, 16'hC001, "R11");
    step(0, 1, 16'h0, "R11");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule